// File: doc/BRIEF.md
# Interrupt Acknowledge Cycle Handler

This block services the seven prioritised interrupt request lines of a backplane bus on its own, without the host processor. It watches request levels 1 to 7. Among the levels that are both pending and enabled in a configuration mask, it picks the highest. It then asks for bus ownership. Once ownership is granted, it runs an acknowledge cycle that puts the chosen level on the address lines.

The interrupter answers with an 8-bit status/ID. The handler captures that vector and queues the level together with the vector for the host. It supports only interrupters that release their request when acknowledged. No register access is needed to clear a request. A bus error ends the cycle without a vector and sets a sticky error flag.

The host side is a valid/ready stream. An entry is transferred on each clock edge where `out_valid_o` and `out_ready_i` are both high. While `out_valid_o` is high and `out_ready_i` is low, the entry is held unchanged. Back-pressure travels upstream through the queue. While the queue is full, no new acknowledge cycle is started, so no vector can ever be dropped.

Top module: `iack_handler`

## Requirements
- R1: After reset, `bus_req_o`, `iack_o`, `ds_lo_o`, `out_valid_o`, `err_o` and `cfg_rej_o` are low, and the mask `cfg_mask_o` is all zero.
- R2: A mask write (`cfg_we_i`) with six or fewer bits set is taken on the clock edge. Bit k of the mask enables level k+1, and the new mask is visible on `cfg_mask_o` in the next cycle.
- R3: A mask write that sets all seven bits is rejected. The mask keeps its previous value, and `cfg_rej_o` is high for exactly the one cycle after that write edge.
- R4: A pending level whose mask bit is clear is ignored. It raises no bus request and no acknowledge cycle.
- R5: Before any acknowledge cycle, the block raises `bus_req_o`. `iack_o` is not asserted until `bus_gnt_i` has been seen high, and `bus_req_o` stays high for the whole cycle.
- R6: When several enabled levels are pending, the highest level number is acknowledged first (7 highest, 1 lowest). The level is driven in binary on `addr_o` (address bits 3:1).
- R7: During an acknowledge cycle, `iack_o` and `ds_lo_o` are both high, and `addr_o` stays stable until the cycle ends.
- R8: `dtack_i` ends the cycle. On that edge, `data_i[7:0]` is captured and {level, vector} is pushed into the output queue.
- R9: `berr_i` without `dtack_i` ends the cycle with no queue entry and sets `err_o`. `err_o` stays high until `err_clr_i` is pulsed.
- R10: In the cycle after the cycle ends, `iack_o`, `ds_lo_o` and `bus_req_o` are low. No new cycle starts while `dtack_i` or `berr_i` is still asserted.
- R11: The queue delivers entries in acknowledge order and holds an entry stable while it is not accepted. While the queue is full, no new bus request is raised.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| irq_i | input | 7 | Request lines, bit k = level k+1, active high |
| cfg_we_i | input | 1 | Mask write strobe |
| cfg_mask_i | input | 7 | Mask write data |
| cfg_mask_o | output | 7 | Current enable mask |
| cfg_rej_o | output | 1 | One-cycle pulse after a rejected mask write |
| err_clr_i | input | 1 | Clears the bus-error flag |
| err_o | output | 1 | Sticky flag: an acknowledge cycle ended in bus error |
| bus_req_o | output | 1 | Bus ownership request |
| bus_gnt_i | input | 1 | Bus ownership grant |
| iack_o | output | 1 | Acknowledge line |
| ds_lo_o | output | 1 | Low-byte data strobe |
| addr_o | output | 3 | Acknowledged level on address bits 3:1 |
| data_i | input | 8 | Status/ID from the interrupter |
| dtack_i | input | 1 | Data acknowledge from the interrupter |
| berr_i | input | 1 | Bus error |
| out_valid_o | output | 1 | Queue head valid |
| out_ready_i | input | 1 | Host accepts queue head |
| out_level_o | output | 3 | Level of the queue head |
| out_vector_o | output | 8 | Status/ID of the queue head |

## Verification
The bench builds the block with its defaults: a queue depth of four and a limit of six enabled levels. With a depth of four, a handful of acknowledges is enough to fill the queue, so the stall on a full queue and the restart after one pop are both exercised. The limit of six makes the single rejected pattern (all seven bits) reachable with a one-line write.

// File: rtl/iack_pkg.sv
package iack_pkg;
  localparam int NUM_LVL = 7;
  localparam int LVL_W   = $clog2(NUM_LVL + 1);
  localparam int VEC_W   = 8;

  typedef struct packed {
    logic [LVL_W-1:0] lvl;
    logic [VEC_W-1:0] vec;
  } iack_entry_t;

  typedef enum logic [1:0] {
    S_IDLE = 2'd0,
    S_REQ  = 2'd1,
    S_ACK  = 2'd2,
    S_DONE = 2'd3
  } iack_state_t;
endpackage

// File: rtl/iack_prio_enc.sv
module iack_prio_enc
  import iack_pkg::*;
(
  input  logic [NUM_LVL-1:0] req_i,
  output logic               any_o,
  output logic [LVL_W-1:0]   lvl_o
);
  // higher index wins: the later assignment overrides the earlier one
  always_comb begin
    lvl_o = '0;
    for (int i = 0; i < NUM_LVL; i++) begin
      if (req_i[i]) lvl_o = LVL_W'(i + 1);
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/iack_mask_reg.sv
module iack_mask_reg
  import iack_pkg::*;
#(
  parameter int MAX_ENABLED = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               we_i,
  input  logic [NUM_LVL-1:0] wdata_i,
  output logic [NUM_LVL-1:0] mask_o,
  output logic               rej_o
);
  logic over_limit;
  assign over_limit = $countones(wdata_i) > MAX_ENABLED;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_o <= '0;
      rej_o  <= 1'b0;
    end else begin
      rej_o <= we_i && over_limit;
      if (we_i && !over_limit) mask_o <= wdata_i;
    end
  end
endmodule

// File: rtl/iack_seq.sv
module iack_seq
  import iack_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             pend_any_i,
  input  logic [LVL_W-1:0] pend_lvl_i,
  input  logic             q_full_i,
  input  logic             bus_gnt_i,
  input  logic             dtack_i,
  input  logic             berr_i,
  input  logic             err_clr_i,
  output logic             bus_req_o,
  output logic             iack_o,
  output logic             ds_lo_o,
  output logic [LVL_W-1:0] addr_o,
  output logic             push_o,
  output logic             err_o
);
  iack_state_t      state_q;
  logic [LVL_W-1:0] lvl_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      lvl_q   <= '0;
      err_o   <= 1'b0;
    end else begin
      if (err_clr_i) err_o <= 1'b0;
      unique case (state_q)
        S_IDLE: if (pend_any_i && !q_full_i) state_q <= S_REQ;
        S_REQ: begin
          if (!pend_any_i) begin
            state_q <= S_IDLE;
          end else if (bus_gnt_i) begin
            lvl_q   <= pend_lvl_i;
            state_q <= S_ACK;
          end
        end
        S_ACK: begin
          if (dtack_i) begin
            state_q <= S_DONE;
          end else if (berr_i) begin
            err_o   <= 1'b1;
            state_q <= S_DONE;
          end
        end
        S_DONE: if (!dtack_i && !berr_i) state_q <= S_IDLE;
        default: state_q <= S_IDLE;
      endcase
    end
  end

  assign bus_req_o = (state_q == S_REQ) || (state_q == S_ACK);
  assign iack_o    = (state_q == S_ACK);
  assign ds_lo_o   = (state_q == S_ACK);
  assign addr_o    = (state_q == S_ACK) ? lvl_q : '0;
  assign push_o    = (state_q == S_ACK) && dtack_i;
endmodule

// File: rtl/iack_fifo.sv
module iack_fifo #(
  parameter int W     = 11,
  parameter int DEPTH = 4
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         push_i,
  input  logic [W-1:0] data_i,
  output logic         full_o,
  output logic         valid_o,
  input  logic         ready_i,
  output logic [W-1:0] data_o
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [W-1:0]  mem [DEPTH];
  logic [AW-1:0] wr_q, rd_q;
  logic [CW-1:0] cnt_q;
  logic          do_push, do_pop;

  assign full_o  = (cnt_q == CW'(DEPTH));
  assign valid_o = (cnt_q != '0);
  assign do_push = push_i && !full_o;
  assign do_pop  = valid_o && ready_i;
  assign data_o  = mem[rd_q];

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk) begin
    if (do_push) mem[wr_q] <= data_i;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wr_q  <= '0;
      rd_q  <= '0;
      cnt_q <= '0;
    end else begin
      if (do_push) wr_q <= nxt(wr_q);
      if (do_pop)  rd_q <= nxt(rd_q);
      if (do_push && !do_pop)      cnt_q <= cnt_q + 1'b1;
      else if (do_pop && !do_push) cnt_q <= cnt_q - 1'b1;
    end
  end
endmodule

// File: rtl/iack_handler.sv
module iack_handler
  import iack_pkg::*;
#(
  parameter int FIFO_DEPTH  = 4,
  parameter int MAX_ENABLED = 6
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic [NUM_LVL-1:0] irq_i,
  input  logic               cfg_we_i,
  input  logic [NUM_LVL-1:0] cfg_mask_i,
  output logic [NUM_LVL-1:0] cfg_mask_o,
  output logic               cfg_rej_o,
  input  logic               err_clr_i,
  output logic               err_o,
  output logic               bus_req_o,
  input  logic               bus_gnt_i,
  output logic               iack_o,
  output logic               ds_lo_o,
  output logic [LVL_W-1:0]   addr_o,
  input  logic [VEC_W-1:0]   data_i,
  input  logic               dtack_i,
  input  logic               berr_i,
  output logic               out_valid_o,
  input  logic               out_ready_i,
  output logic [LVL_W-1:0]   out_level_o,
  output logic [VEC_W-1:0]   out_vector_o
);
  localparam int ENTRY_W = $bits(iack_entry_t);

  logic             pend_any, q_full, push;
  logic [LVL_W-1:0] pend_lvl;
  iack_entry_t      in_e, out_e;

  iack_mask_reg #(.MAX_ENABLED(MAX_ENABLED)) mask_i (
    .clk(clk), .rst_n(rst_n), .we_i(cfg_we_i), .wdata_i(cfg_mask_i),
    .mask_o(cfg_mask_o), .rej_o(cfg_rej_o)
  );

  iack_prio_enc enc_i (
    .req_i(irq_i & cfg_mask_o), .any_o(pend_any), .lvl_o(pend_lvl)
  );

  iack_seq seq_i (
    .clk(clk), .rst_n(rst_n), .pend_any_i(pend_any), .pend_lvl_i(pend_lvl),
    .q_full_i(q_full), .bus_gnt_i(bus_gnt_i), .dtack_i(dtack_i),
    .berr_i(berr_i), .err_clr_i(err_clr_i), .bus_req_o(bus_req_o),
    .iack_o(iack_o), .ds_lo_o(ds_lo_o), .addr_o(addr_o), .push_o(push),
    .err_o(err_o)
  );

  assign in_e.lvl = addr_o;
  assign in_e.vec = data_i;

  iack_fifo #(.W(ENTRY_W), .DEPTH(FIFO_DEPTH)) q_i (
    .clk(clk), .rst_n(rst_n), .push_i(push), .data_i(in_e),
    .full_o(q_full), .valid_o(out_valid_o), .ready_i(out_ready_i),
    .data_o(out_e)
  );

  assign out_level_o  = out_e.lvl;
  assign out_vector_o = out_e.vec;
endmodule

// File: rtl/iack_handler_chk.sv
module iack_handler_chk
  import iack_pkg::*;
#(
  parameter int MAX_ENABLED = 6
) (
  input logic               clk,
  input logic               rst_n,
  input logic [NUM_LVL-1:0] cfg_mask_o,
  input logic               err_o,
  input logic               bus_req_o,
  input logic               iack_o,
  input logic [LVL_W-1:0]   addr_o,
  input logic               dtack_i,
  input logic               berr_i,
  input logic               out_valid_o,
  input logic               out_ready_i,
  input logic [LVL_W-1:0]   out_level_o,
  input logic [VEC_W-1:0]   out_vector_o
);
  a_r3_mask_limit: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(cfg_mask_o) <= MAX_ENABLED);

  a_r5_iack_under_req: assert property (@(posedge clk) disable iff (!rst_n)
    iack_o |-> bus_req_o);

  a_r7_addr_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_o && $past(iack_o)) |-> $stable(addr_o));

  a_r8_valid_after_dtack: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(out_valid_o) |-> $past(dtack_i));

  a_r9_err_on_berr: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_o && berr_i && !dtack_i) |=> err_o);

  a_r10_release: assert property (@(posedge clk) disable iff (!rst_n)
    (iack_o && (dtack_i || berr_i)) |=> (!iack_o && !bus_req_o));

  a_r11_hold: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid_o && !out_ready_i) |=>
      (out_valid_o && $stable(out_level_o) && $stable(out_vector_o)));
endmodule

bind iack_handler iack_handler_chk #(.MAX_ENABLED(MAX_ENABLED)) chk_i (
  .clk(clk), .rst_n(rst_n), .cfg_mask_o(cfg_mask_o), .err_o(err_o),
  .bus_req_o(bus_req_o), .iack_o(iack_o), .addr_o(addr_o),
  .dtack_i(dtack_i), .berr_i(berr_i), .out_valid_o(out_valid_o),
  .out_ready_i(out_ready_i), .out_level_o(out_level_o),
  .out_vector_o(out_vector_o)
);

// File: tb/iack_handler_tb.sv
module iack_handler_tb_top;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [6:0] irq = '0;
  logic       cfg_we = 1'b0;
  logic [6:0] cfg_wd = '0;
  logic [6:0] mask;
  logic       rej, err_clr = 1'b0, err;
  logic       bus_req, gnt = 1'b0, gnt_block = 1'b0;
  logic       iack, ds_lo;
  logic [2:0] addr;
  logic [7:0] data = '0;
  logic       dtack = 1'b0, berr = 1'b0;
  logic       out_valid, out_ready = 1'b0;
  logic [2:0] out_level;
  logic [7:0] out_vector;
  int         n_chk = 0, n_fail = 0;

  always #2 clk = ~clk;

  always @(posedge clk) gnt <= rst_n && bus_req && !gnt_block;

  iack_handler dut_i (
    .clk(clk), .rst_n(rst_n), .irq_i(irq), .cfg_we_i(cfg_we),
    .cfg_mask_i(cfg_wd), .cfg_mask_o(mask), .cfg_rej_o(rej),
    .err_clr_i(err_clr), .err_o(err), .bus_req_o(bus_req),
    .bus_gnt_i(gnt), .iack_o(iack), .ds_lo_o(ds_lo), .addr_o(addr),
    .data_i(data), .dtack_i(dtack), .berr_i(berr),
    .out_valid_o(out_valid), .out_ready_i(out_ready),
    .out_level_o(out_level), .out_vector_o(out_vector)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic cycles(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  task automatic set_mask(input logic [6:0] m);
    @(negedge clk); cfg_wd = m; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    chk(mask == m, "R2 mask accepted", mask, m);
  endtask

  // plays a release-on-acknowledge interrupter for one cycle
  task automatic respond(input int lvl, input logic [7:0] vec, input bit bus_err);
    int waited = 0;
    while (!iack && waited < 60) begin @(negedge clk); waited++; end
    chk(iack, "R5 acknowledge cycle started", iack, 1);
    chk(int'(addr) == lvl, "R6 level on address", addr, lvl);
    chk(ds_lo && bus_req, "R7 strobe and request during cycle", ds_lo, 1);
    @(negedge clk);
    chk(iack && int'(addr) == lvl, "R7 address stable", addr, lvl);
    data = vec;
    if (bus_err) berr = 1'b1; else dtack = 1'b1;
    irq[lvl-1] = 1'b0;
    @(negedge clk);
    chk(!iack && !ds_lo && !bus_req, "R10 released after cycle", iack, 0);
    @(negedge clk);
    chk(!bus_req, "R10 no restart while response held", bus_req, 0);
    dtack = 1'b0; berr = 1'b0;
  endtask

  task automatic pop(input int lvl, input logic [7:0] vec);
    @(negedge clk);
    chk(out_valid, "R11 entry present", out_valid, 1);
    chk(int'(out_level) == lvl, "R8 queued level", out_level, lvl);
    chk(out_vector == vec, "R8 queued vector", out_vector, vec);
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
  endtask

  task automatic t_reset;
    chk(!bus_req && !iack && !ds_lo, "R1 bus idle", bus_req, 0);
    chk(!out_valid && !err && !rej, "R1 flags low", out_valid, 0);
    chk(mask == 7'd0, "R1 mask cleared", mask, 0);
  endtask

  task automatic t_mask_limit;
    set_mask(7'b0111111);
    @(negedge clk); cfg_wd = 7'b1111111; cfg_we = 1'b1;
    @(negedge clk); cfg_we = 1'b0;
    chk(rej, "R3 reject pulse", rej, 1);
    chk(mask == 7'b0111111, "R3 mask kept", mask, 7'b0111111);
    @(negedge clk);
    chk(!rej, "R3 pulse one cycle", rej, 0);
  endtask

  task automatic t_masked_ignored;
    set_mask(7'b0000101);
    irq[1] = 1'b1;
    cycles(10);
    chk(!bus_req && !iack, "R4 masked level ignored", bus_req, 0);
    irq[0] = 1'b1;
    respond(1, 8'h11, 1'b0);
    cycles(6);
    chk(!bus_req, "R4 masked level still ignored", bus_req, 0);
    irq[1] = 1'b0;
    pop(1, 8'h11);
  endtask

  task automatic t_priority;
    set_mask(7'b1111110);
    irq[2] = 1'b1; irq[4] = 1'b1; irq[6] = 1'b1;
    respond(7, 8'hA7, 1'b0);
    respond(5, 8'h5C, 1'b0);
    respond(3, 8'h03, 1'b0);
    cycles(3);
    chk(out_valid && out_level == 3'd7 && out_vector == 8'hA7,
        "R11 head held while not ready", out_vector, 8'hA7);
    pop(7, 8'hA7);
    pop(5, 8'h5C);
    pop(3, 8'h03);
    @(negedge clk);
    chk(!out_valid, "R11 queue drained", out_valid, 0);
  endtask

  task automatic t_full;
    set_mask(7'b0000011);
    for (int k = 0; k < 4; k++) begin
      irq[0] = 1'b1;
      respond(1, 8'(k + 1), 1'b0);
    end
    irq[1] = 1'b1;
    cycles(8);
    chk(!bus_req, "R11 no request while queue full", bus_req, 0);
    pop(1, 8'h01);
    respond(2, 8'hEE, 1'b0);
    pop(1, 8'h02);
    pop(1, 8'h03);
    pop(1, 8'h04);
    pop(2, 8'hEE);
  endtask

  task automatic t_berr;
    set_mask(7'b0001000);
    irq[3] = 1'b1;
    respond(4, 8'h99, 1'b1);
    cycles(3);
    chk(!out_valid, "R9 no entry on bus error", out_valid, 0);
    chk(err, "R9 error flag sticky", err, 1);
    err_clr = 1'b1; @(negedge clk); err_clr = 1'b0;
    chk(!err, "R9 error flag cleared", err, 0);
  endtask

  task automatic t_grant_wait;
    set_mask(7'b0100000);
    gnt_block = 1'b1;
    irq[5] = 1'b1;
    cycles(8);
    chk(bus_req && !iack, "R5 no cycle before grant", iack, 0);
    gnt_block = 1'b0;
    respond(6, 8'h66, 1'b0);
    pop(6, 8'h66);
  endtask

  initial begin
    cycles(3);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_mask_limit();
    t_masked_ignored();
    t_priority();
    t_full();
    t_berr();
    t_grant_wait();
    cycles(2);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    cycles(20000);
    n_fail++;
    $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule